// File: doc/BRIEF.md
# Fill-Level Locked Delay Buffer

This block holds an audio delay in a circular sample memory. A fixed-rate read tick from outside drains one sample per tick, so the output rate never moves and any filtering downstream can stay fixed. Samples are written on strobes from an internal numerically controlled oscillator. The oscillator is an `ACC_W`-bit phase accumulator that advances by a trimmed increment on every system clock.

The delay is set by a control loop rather than by an address offset. The loop measures the buffer occupancy: completed writes minus completed reads, with the accumulator's phase fraction appended as `FRAC_W` extra low bits. It subtracts that occupancy from the requested delay word. The difference passes through a proportional-integral filter that steers the oscillator increment around its nominal value. When the requested delay changes, the write timing slides against the read timing. The delay then glides at sub-sample resolution, and the output is pitch-shifted while it moves.

The upstream source presents a new input sample whenever the block raises its write request. A lock flag reports a settled loop. One-cycle flags report a dropped write on a full buffer and a read on an empty buffer.

Top module: `fill_locked_delay`

## Requirements
- R1: While reset is active, and on the first active cycle after it, `dout` is 0 and `locked`, `overflow`, `underflow` and `wr_req` are 0. The oscillator starts at phase 0 with the nominal increment.
- R2: `wr_req` is high in each cycle where adding the increment to the `ACC_W`-bit accumulator carries out. At the nominal increment `NOM_INC`, strobes are exactly 2^ACC_W / NOM_INC clocks apart.
- R3: A sample presented on `din` in a cycle with `wr_req` high is stored, unless the write is dropped. Stored samples leave in write order. `dout` takes the next stored sample on the clock edge that ends a cycle with `rd_tick` high.
- R4: Until the integer part of the occupancy (`target[TGT_W-1:FRAC_W]` compared with whole samples) has been reached once, read ticks are ignored, `dout` stays 0 and the loop holds the nominal increment.
- R5: `dout` changes only on the edge that ends a cycle with `rd_tick` high.
- R6: A write request that arrives with 2^ADDR_W samples held is dropped, and `overflow` is high for the following cycle only.
- R7: A read tick after priming that arrives with no samples held leaves `dout` unchanged, and `underflow` is high for the following cycle only.
- R8: On each primed read tick, error = target minus fractional occupancy. The new increment is `NOM_INC` + clamp((error >>> KP_SH) + (integrator >>> KI_SH), ±INC_SPAN). The integrator adds the error and saturates at ±(INC_SPAN << KI_SH). Write strobes are therefore never closer than 2^ACC_W/(NOM_INC+INC_SPAN) clocks and never further apart than 2^ACC_W/(NOM_INC-INC_SPAN) clocks.
- R9: After a change of `target`, the occupancy settles to within two samples of the new integer delay by the time lock returns.
- R10: `locked` rises on the `LOCK_CNT`-th consecutive primed read tick with |error| < `LOCK_THR`. It falls on the edge after the first primed read tick with |error| ≥ `LOCK_THR`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_tick | input | 1 | One-cycle output-rate strobe |
| din | input | DATA_W | Input sample, valid while `wr_req` is high |
| wr_req | output | 1 | Write strobe from the internal oscillator |
| target | input | ADDR_W+1+FRAC_W | Requested delay in samples, FRAC_W fraction bits |
| dout | output | DATA_W | Delayed output sample |
| locked | output | 1 | Loop settled |
| overflow | output | 1 | A write was dropped on a full buffer |
| underflow | output | 1 | A read found the buffer empty |

## Verification
The bench starts on the nominal write cadence during priming. A design that let reads through early, or that trimmed the oscillator before priming, would show a nonzero output or uneven strobe spacing. A step of four samples in the delay must break lock on the very next read tick and restore it only after the full qualifying count. A lock flag that lagged or rose early is caught by these checks. Running reads at four times the write rate drains the buffer, and stopping them fills it. Those two phases expose a design that lets out a stale or wrong sample on an empty read, that overwrites data when full, or that leaves the oscillator increment unclamped, which would squeeze the write strobes below the minimum spacing.

// File: rtl/fld_pkg.sv
package fld_pkg;
  typedef struct packed {
    logic ovf;
    logic unf;
  } fld_flags_t;
endpackage

// File: rtl/fld_dco.sv
module fld_dco #(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] phase,
  output logic             wr_req
);
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_q, acc_n;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, inc};
    acc_n = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end

  assign phase  = acc_q;
  assign wr_req = sum[ACC_W];
endmodule

// File: rtl/fld_pi.sv
module fld_pi #(
  parameter int ERR_W    = 14,
  parameter int ACC_W    = 8,
  parameter int NOM_INC  = 16,
  parameter int INC_SPAN = 8,
  parameter int KP_SH    = 6,
  parameter int KI_SH    = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic signed [ERR_W-1:0] err,
  output logic [ACC_W-1:0]        inc
);
  localparam int IW = ERR_W + KI_SH + 2;
  localparam logic signed [IW-1:0] I_HI = IW'(INC_SPAN << KI_SH);
  localparam logic signed [IW-1:0] I_LO = -I_HI;
  localparam logic signed [IW-1:0] U_HI = IW'(INC_SPAN);
  localparam logic signed [IW-1:0] U_LO = -U_HI;

  logic signed [IW-1:0] e_x, i_sum, u_raw, u_cl, integ_q, integ_n;
  logic [ACC_W-1:0]     inc_q, inc_n;

  always_comb begin
    e_x   = {{(IW-ERR_W){err[ERR_W-1]}}, err};
    i_sum = integ_q + e_x;
    u_raw = (e_x >>> KP_SH) + (integ_q >>> KI_SH);
    if (u_raw > U_HI)      u_cl = U_HI;
    else if (u_raw < U_LO) u_cl = U_LO;
    else                   u_cl = u_raw;
    integ_n = integ_q;
    inc_n   = inc_q;
    if (upd) begin
      if (i_sum > I_HI)      integ_n = I_HI;
      else if (i_sum < I_LO) integ_n = I_LO;
      else                   integ_n = i_sum;
      inc_n = ACC_W'(NOM_INC + int'(u_cl));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      inc_q   <= ACC_W'(NOM_INC);
    end else begin
      integ_q <= integ_n;
      inc_q   <= inc_n;
    end
  end

  assign inc = inc_q;
endmodule

// File: rtl/fld_ring.sv
module fld_ring
  import fld_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_en,
  output logic [DATA_W-1:0] dout,
  output logic [ADDR_W:0]   fill,
  output logic [ADDR_W:0]   wr_cnt,
  output fld_flags_t        flags
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W:0]   wr_q, wr_n, rd_q, rd_n;
  logic [DATA_W-1:0] dout_q, dout_n;
  fld_flags_t        flg_q, flg_n;
  logic              full, empty, wr_ok, rd_ok;

  always_comb begin
    fill   = wr_q - rd_q;
    full   = (fill == (ADDR_W+1)'(DEPTH));
    empty  = (fill == '0);
    wr_ok  = wr_req & ~full;
    rd_ok  = rd_en & ~empty;
    wr_n   = wr_ok ? wr_q + 1'b1 : wr_q;
    rd_n   = rd_ok ? rd_q + 1'b1 : rd_q;
    dout_n = rd_ok ? mem[rd_q[ADDR_W-1:0]] : dout_q;
    flg_n.ovf = wr_req & full;
    flg_n.unf = rd_en & empty;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_q[ADDR_W-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      dout_q <= '0;
      flg_q  <= '0;
    end else begin
      wr_q   <= wr_n;
      rd_q   <= rd_n;
      dout_q <= dout_n;
      flg_q  <= flg_n;
    end
  end

  assign dout   = dout_q;
  assign wr_cnt = wr_q;
  assign flags  = flg_q;
endmodule

// File: rtl/fill_locked_delay.sv
module fill_locked_delay
  import fld_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4,
  parameter int ACC_W    = 8,
  parameter int FRAC_W   = 8,
  parameter int NOM_INC  = 16,
  parameter int INC_SPAN = 8,
  parameter int KP_SH    = 6,
  parameter int KI_SH    = 10,
  parameter int LOCK_THR = 128,
  parameter int LOCK_CNT = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_tick,
  input  logic [DATA_W-1:0]          din,
  output logic                       wr_req,
  input  logic [ADDR_W+FRAC_W:0]     target,
  output logic [DATA_W-1:0]          dout,
  output logic                       locked,
  output logic                       overflow,
  output logic                       underflow
);
  localparam int TGT_W = ADDR_W + 1 + FRAC_W;
  localparam int ERR_W = TGT_W + 1;
  localparam int CW    = $clog2(LOCK_CNT + 1);

  logic                    rs1_q, rst_sync_n;
  logic [ACC_W-1:0]        inc, phase;
  logic [ADDR_W:0]         fill, wr_cnt;
  logic [TGT_W-1:0]        fill_fx;
  logic signed [ERR_W-1:0] err;
  logic [ERR_W-1:0]        abs_err;
  logic                    primed_q, primed_n, upd;
  logic [CW-1:0]           lcnt_q, lcnt_n;
  logic                    locked_q, locked_n;
  fld_flags_t              flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs1_q      <= 1'b1;
      rst_sync_n <= rs1_q;
    end
  end

  fld_dco #(.ACC_W(ACC_W)) u_dco (
    .clk(clk), .rst_n(rst_sync_n), .inc(inc), .phase(phase), .wr_req(wr_req)
  );

  fld_ring #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ring (
    .clk(clk), .rst_n(rst_sync_n), .wr_req(wr_req), .din(din),
    .rd_en(rd_tick & primed_q), .dout(dout), .fill(fill),
    .wr_cnt(wr_cnt), .flags(flags)
  );

  fld_pi #(
    .ERR_W(ERR_W), .ACC_W(ACC_W), .NOM_INC(NOM_INC), .INC_SPAN(INC_SPAN),
    .KP_SH(KP_SH), .KI_SH(KI_SH)
  ) u_pi (
    .clk(clk), .rst_n(rst_sync_n), .upd(upd), .err(err), .inc(inc)
  );

  always_comb begin
    fill_fx  = {fill, phase[ACC_W-1 -: FRAC_W]};
    err      = $signed({1'b0, target}) - $signed({1'b0, fill_fx});
    abs_err  = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
    primed_n = primed_q | (fill >= target[TGT_W-1:FRAC_W]);
    upd      = rd_tick & primed_q;
    lcnt_n   = lcnt_q;
    locked_n = locked_q;
    if (upd) begin
      if (abs_err < ERR_W'(LOCK_THR)) begin
        if (lcnt_q != CW'(LOCK_CNT)) lcnt_n = lcnt_q + 1'b1;
        locked_n = (lcnt_n == CW'(LOCK_CNT));
      end else begin
        lcnt_n   = '0;
        locked_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      primed_q <= 1'b0;
      lcnt_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      primed_q <= primed_n;
      lcnt_q   <= lcnt_n;
      locked_q <= locked_n;
    end
  end

  assign locked    = locked_q;
  assign overflow  = flags.ovf;
  assign underflow = flags.unf;
endmodule

// File: rtl/fld_checker.sv
module fld_checker #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4,
  parameter int ACC_W    = 8,
  parameter int ERR_W    = 14,
  parameter int NOM_INC  = 16,
  parameter int INC_SPAN = 8,
  parameter int LOCK_THR = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_tick,
  input logic              wr_req,
  input logic [DATA_W-1:0] dout,
  input logic              locked,
  input logic              underflow,
  input logic              primed,
  input logic [ADDR_W:0]   fill,
  input logic [ADDR_W:0]   wr_cnt,
  input logic [ACC_W-1:0]  inc,
  input logic [ERR_W-1:0]  abs_err
);
  localparam logic [ADDR_W:0]  FULL   = (ADDR_W+1)'(1 << ADDR_W);
  localparam logic [ACC_W-1:0] INC_LO = ACC_W'(NOM_INC - INC_SPAN);
  localparam logic [ACC_W-1:0] INC_HI = ACC_W'(NOM_INC + INC_SPAN);

  AST_INC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc >= INC_LO) && (inc <= INC_HI)); // R8
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && fill == FULL) |=> (wr_cnt == $past(wr_cnt))); // R6
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $stable(dout)); // R7
  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_tick |=> $stable(dout)); // R5
  AST_UNPRIMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> (dout == '0)); // R4
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_tick && primed && abs_err >= ERR_W'(LOCK_THR)) |=> !locked); // R10
endmodule

bind fill_locked_delay fld_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACC_W(ACC_W), .ERR_W(ERR_W),
  .NOM_INC(NOM_INC), .INC_SPAN(INC_SPAN), .LOCK_THR(LOCK_THR)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .rd_tick(rd_tick), .wr_req(wr_req),
  .dout(dout), .locked(locked), .underflow(underflow), .primed(primed_q),
  .fill(fill), .wr_cnt(wr_cnt), .inc(inc), .abs_err(abs_err)
);

// File: tb/fill_locked_delay_tb_top.sv
module fill_locked_delay_tb_top;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int FRAC_W = 8;
  localparam int DEPTH  = 16;
  localparam int LOCK_CNT = 8;
  localparam int TGT_W  = ADDR_W + 1 + FRAC_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rd_tick = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [TGT_W-1:0]  target = TGT_W'(6 * 256);
  logic              wr_req, locked, overflow, underflow;
  logic [DATA_W-1:0] dout;

  fill_locked_delay dut_i (
    .clk(clk), .rst_n(rst_n), .rd_tick(rd_tick), .din(din), .wr_req(wr_req),
    .target(target), .dout(dout), .locked(locked), .overflow(overflow),
    .underflow(underflow)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  int rd_period = 16;
  bit sb_on = 1'b0;
  logic [DATA_W-1:0] sb_q[$];
  logic [DATA_W-1:0] exp_dout = '0;
  bit exp_ov = 1'b0, exp_un = 1'b0, primed_m = 1'b0;
  int fill_m = 0, cyc = 0, last_wr = -1, last_iv = 0;
  int min_iv = 1000, max_iv = 0, ovf_seen = 0, unf_seen = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // driver: new sample every clock, read tick at the selected rate
  initial begin
    int c = 0;
    forever begin
      @(posedge clk);
      #1;
      din = din + 1'b1;
      if (rd_period == 0) begin
        rd_tick = 1'b0;
        c = 0;
      end else begin
        c = (c + 1 >= rd_period) ? 0 : c + 1;
        rd_tick = (c == 0);
      end
    end
  end

  // monitor and scoreboard
  always @(negedge clk) begin : mon
    int iv;
    bit rd_go, wr_go, un_now, ov_now, pr_now;
    if (sb_on) begin
      cyc++;
      check(dout === exp_dout, "R3 R5 output sample", dout, exp_dout);
      check(overflow === exp_ov, "R6 overflow flag", overflow, exp_ov);
      check(underflow === exp_un, "R7 underflow flag", underflow, exp_un);
      if (!primed_m) check(dout == '0, "R4 output before priming", dout, 0);
      if (overflow) ovf_seen++;
      if (underflow) unf_seen++;
      if (wr_req) begin
        if (last_wr >= 0) begin
          iv = cyc - last_wr;
          last_iv = iv;
          if (iv < min_iv) min_iv = iv;
          if (iv > max_iv) max_iv = iv;
          if (!primed_m) check(iv == 16, "R2 nominal strobe spacing", iv, 16);
        end
        last_wr = cyc;
      end
      rd_go  = rd_tick && primed_m && fill_m > 0;
      un_now = rd_tick && primed_m && fill_m == 0;
      wr_go  = wr_req && fill_m < DEPTH;
      ov_now = wr_req && fill_m == DEPTH;
      pr_now = primed_m || (fill_m >= int'(target[TGT_W-1:FRAC_W]));
      if (rd_go) exp_dout = sb_q.pop_front();
      if (wr_go) sb_q.push_back(din);
      fill_m = fill_m + (wr_go ? 1 : 0) - (rd_go ? 1 : 0);
      primed_m = pr_now;
      exp_ov = ov_now;
      exp_un = un_now;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(dout == '0, "R1 reset dout", dout, 0);
    check(locked == 1'b0, "R1 reset locked", locked, 0);
    check(overflow == 1'b0, "R1 reset overflow", overflow, 0);
    check(underflow == 1'b0, "R1 reset underflow", underflow, 0);
    check(wr_req == 1'b0, "R1 reset wr_req", wr_req, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk); #1 sb_on = 1'b1;

    n = 0;
    while (!locked && n < 8000) begin @(negedge clk); n++; end
    check(locked == 1'b1, "R10 initial lock", locked, 1);
    check((fill_m >= 4) && (fill_m <= 8), "R9 settled delay 6", fill_m, 6);

    @(posedge clk); #2 target = TGT_W'(10 * 256);
    @(negedge clk);
    while (!rd_tick) @(negedge clk);
    @(negedge clk);
    check(locked == 1'b0, "R10 lock lost after step", locked, 0);
    n = 0;
    while (!locked && n < 500) begin
      @(negedge clk);
      if (rd_tick) n++;
    end
    check(locked == 1'b1, "R10 relock", locked, 1);
    check(n >= LOCK_CNT, "R10 qualifying ticks", n, LOCK_CNT);
    check((fill_m >= 8) && (fill_m <= 12), "R9 settled delay 10", fill_m, 10);

    rd_period = 4;
    repeat (400) @(negedge clk);
    check(unf_seen > 0, "R7 underflow reached", unf_seen, 1);
    check(last_iv <= 11, "R8 saturated fast strobes", last_iv, 11);

    rd_period = 0;
    repeat (600) @(negedge clk);
    check(ovf_seen > 0, "R6 overflow reached", ovf_seen, 1);
    check(fill_m == DEPTH, "R6 full buffer", fill_m, DEPTH);
    check(min_iv >= 10, "R8 minimum strobe spacing", min_iv, 10);
    check(max_iv <= 32, "R8 maximum strobe spacing", max_iv, 32);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule